// File: doc/BRIEF.md
# Reference Clock Qualification Monitor

This block watches two reference clocks feeding a jitter-cleaning loop and raises one active-low failure flag per reference. A reference is judged on three things: an amplitude-fault bit supplied by an external analog detector, a frequency measurement made by counting its edges against a fixed window of system-clock cycles, and, for the reference currently driving the loop only, a vote over the phase-detector error reported once per comparison cycle.

The frequency check has hysteresis. A tight band is needed to become qualified, and a wide band must be left before qualification is lost. The phase check declares a fault on a six-of-eight violation vote and clears it only after an unbroken run of clean comparisons. The flags do not follow the checks directly. Any failing cycle is caught in a sticky latch, and the flags are refreshed only on an update boundary that comes once per 128 comparison strobes.

Top module: `refq_monitor`

## Requirements
- R1: While `rst_n` is low both bits of `fail_n_o` are 1, and they stay 1 until the first update boundary after reset.
- R2: An update boundary is the clock edge that accepts a `perr_vld_i` strobe that is the `UPD_LEN`-th (default 128) strobe since reset or since the previous boundary. `fail_n_o` changes on no other edge.
- R3: At each clock edge an input is failing if its failure condition (R11) holds, evaluated from the state before that edge. A flag goes low at a boundary if its input was failing on any edge from the one after the previous boundary up to and including this boundary edge. Even a single-cycle amplitude fault is therefore shown at the next boundary. A flag returns high only after a whole interval with no failing edge.
- R4: Each reference passes through a two-stage synchronizer followed by rising-edge detection. A level sampled at edge k first takes part in edge detection at edge k+2. Edges are counted over a gate of `GATE_CYC` clocks, and the first gate starts at the first edge after reset.
- R5: After reset no reference is frequency-qualified. At the end of a gate an unqualified reference becomes qualified when its count differs from `NOM_EDGES` by at most `NOM_EDGES*QUAL_PM/1000` (integer division; 2.4 % by default).
- R6: A qualified reference loses frequency qualification only when a gate count differs from `NOM_EDGES` by more than `NOM_EDGES*DISQ_PM/1000` (8 % by default). Between the two bands the state is kept, and it changes only at gate ends.
- R7: A strobe is a violation when `perr_i` is strictly greater than `WIN_PS` (default 750 ps). A value equal to `WIN_PS` is inside the window.
- R8: A phase-qualified reference loses qualification when six or more of its last eight accepted strobes are violations.
- R9: After reset no reference is phase-qualified. An unqualified reference becomes qualified after eight consecutive non-violating accepted strobes.
- R10: A strobe is accepted only by the reference named by `sel_i` (0 names reference 0, 1 names reference 1). The phase state of the other reference is frozen and plays no part in its flag.
- R11: The failure condition of reference n is: `amp_fault_i[n]` is 1, or reference n is not frequency-qualified, or `sel_i` names reference n and it is not phase-qualified. Bit n of `fail_n_o` belongs to reference n.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, also the frequency timebase |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_clk_i | input | 2 | Raw reference clocks, asynchronous to `clk` |
| sel_i | input | 1 | Reference currently used by the loop |
| amp_fault_i | input | 2 | Amplitude-fault bits from the analog detector, one per reference |
| perr_i | input | 12 | Phase error of the selected reference in picoseconds, unsigned |
| perr_vld_i | input | 1 | One-cycle strobe per comparison cycle qualifying `perr_i` |
| fail_n_o | output | 2 | Active-low failure flags, one per reference |

## Verification
The sharpest collision is an amplitude fault on the very edge that is an update boundary. That fault must reach the flag at once, while the sticky latch is cleared on the same edge. The bench provokes it by raising the fault for exactly the strobe that completes an interval. A gate end and a boundary edge also fall on the same cycle during long runs, and then the flag must use the frequency state from before the gate result. Both cases are judged by a behavioural model that tracks every clock and is compared with the flags each cycle.

// File: rtl/refq_pkg.sv
package refq_pkg;
    localparam int NUM_REF      = 2;
    localparam int SYNC_DEF     = 2;
    localparam int HIST_DEF     = 8;
    localparam int FAIL_MIN_DEF = 6;
    localparam int RUN_DEF      = 8;
    typedef logic [NUM_REF-1:0] ref_vec_t;
endpackage

// File: rtl/refq_sync_edge.sv
module refq_sync_edge #(
    parameter int STAGES = refq_pkg::SYNC_DEF
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ref_i,
    output logic rise_o
);
    localparam int SW = STAGES + 1;

    typedef struct packed {
        logic [SW-1:0] sh;
    } st_t;

    st_t s_d, s_q;

    always_comb begin
        s_d    = s_q;
        s_d.sh = {s_q.sh[SW-2:0], ref_i};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    // rising edge seen after the synchronizer stages
    assign rise_o = s_q.sh[STAGES-1] & ~s_q.sh[STAGES];
endmodule

// File: rtl/refq_freq_chk.sv
module refq_freq_chk #(
    parameter int GATE_CYC  = 4096,
    parameter int NOM_EDGES = 1024,
    parameter int QUAL_PM   = 24,
    parameter int DISQ_PM   = 80
) (
    input  logic clk,
    input  logic rst_n,
    input  logic gate_end_i,
    input  logic rise_i,
    output logic freq_ok_o
);
    localparam int CW = $clog2(GATE_CYC + 1);
    localparam logic [CW-1:0] NOM_V  = CW'(NOM_EDGES);
    localparam logic [CW-1:0] QUAL_V = CW'(NOM_EDGES * QUAL_PM / 1000);
    localparam logic [CW-1:0] DISQ_V = CW'(NOM_EDGES * DISQ_PM / 1000);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          ok;
    } st_t;

    st_t s_d, s_q;
    logic [CW-1:0] meas;
    logic [CW-1:0] dev;

    always_comb begin
        s_d  = s_q;
        meas = s_q.cnt + CW'(rise_i);
        dev  = (meas >= NOM_V) ? (meas - NOM_V) : (NOM_V - meas);
        if (gate_end_i) begin
            s_d.cnt = '0;
            if (s_q.ok) s_d.ok = (dev <= DISQ_V);
            else        s_d.ok = (dev <= QUAL_V);
        end else begin
            s_d.cnt = meas;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign freq_ok_o = s_q.ok;
endmodule

// File: rtl/refq_phase_chk.sv
module refq_phase_chk #(
    parameter int PERR_W   = 12,
    parameter int WIN_PS   = 750,
    parameter int HIST_LEN = refq_pkg::HIST_DEF,
    parameter int FAIL_MIN = refq_pkg::FAIL_MIN_DEF,
    parameter int RUN_LEN  = refq_pkg::RUN_DEF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              strobe_i,
    input  logic [PERR_W-1:0] perr_i,
    output logic              phase_ok_o
);
    localparam int CW = $clog2(HIST_LEN + 1);
    localparam int RW = $clog2(RUN_LEN + 1);
    localparam logic [PERR_W-1:0] WIN_V  = PERR_W'(WIN_PS);
    localparam logic [CW-1:0]     FAIL_V = CW'(FAIL_MIN);
    localparam logic [RW-1:0]     RUN_V  = RW'(RUN_LEN);

    typedef struct packed {
        logic [HIST_LEN-1:0] hist;
        logic [RW-1:0]       run;
        logic                ok;
    } st_t;

    st_t s_d, s_q;
    logic                viol;
    logic [HIST_LEN-1:0] hist_n;
    logic [RW-1:0]       run_n;

    function automatic logic [CW-1:0] pop(input logic [HIST_LEN-1:0] v);
        logic [CW-1:0] c;
        c = '0;
        for (int i = 0; i < HIST_LEN; i++) c = c + CW'(v[i]);
        return c;
    endfunction

    always_comb begin
        s_d    = s_q;
        viol   = (perr_i > WIN_V);
        hist_n = {s_q.hist[HIST_LEN-2:0], viol};
        if (viol)                run_n = '0;
        else if (s_q.run == RUN_V) run_n = RUN_V;
        else                     run_n = s_q.run + RW'(1);
        if (strobe_i) begin
            s_d.hist = hist_n;
            s_d.run  = run_n;
            if (s_q.ok && (pop(hist_n) >= FAIL_V))
                s_d.ok = 1'b0;
            else if (!s_q.ok && (run_n == RUN_V))
                s_d.ok = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign phase_ok_o = s_q.ok;
endmodule

// File: rtl/refq_flag_latch.sv
module refq_flag_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic boundary_i,
    input  logic fail_now_i,
    output logic fail_n_o
);
    typedef struct packed {
        logic sticky;
        logic flag_n;
    } st_t;

    st_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (boundary_i) begin
            s_d.flag_n = ~(s_q.sticky | fail_now_i);
            s_d.sticky = 1'b0;
        end else begin
            s_d.sticky = s_q.sticky | fail_now_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '{sticky: 1'b0, flag_n: 1'b1};
        else        s_q <= s_d;
    end

    assign fail_n_o = s_q.flag_n;
endmodule

// File: rtl/refq_monitor.sv
module refq_monitor #(
    parameter int GATE_CYC  = 4096,
    parameter int NOM_EDGES = 1024,
    parameter int QUAL_PM   = 24,
    parameter int DISQ_PM   = 80,
    parameter int WIN_PS    = 750,
    parameter int UPD_LEN   = 128,
    parameter int PERR_W    = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        ref_clk_i,
    input  logic              sel_i,
    input  logic [1:0]        amp_fault_i,
    input  logic [PERR_W-1:0] perr_i,
    input  logic              perr_vld_i,
    output logic [1:0]        fail_n_o
);
    import refq_pkg::*;

    localparam int GW = $clog2(GATE_CYC);
    localparam int UW = $clog2(UPD_LEN);
    localparam logic [GW-1:0] GATE_LAST = GW'(GATE_CYC - 1);
    localparam logic [UW-1:0] UPD_LAST  = UW'(UPD_LEN - 1);

    typedef struct packed {
        logic [GW-1:0] gate;
        logic [UW-1:0] upd;
    } st_t;

    st_t s_d, s_q;
    logic     gate_end;
    logic     upd_boundary;
    ref_vec_t rise;
    ref_vec_t freq_ok;
    ref_vec_t phase_ok;
    ref_vec_t fail_now;

    assign gate_end     = (s_q.gate == GATE_LAST);
    assign upd_boundary = perr_vld_i && (s_q.upd == UPD_LAST);

    always_comb begin
        s_d      = s_q;
        s_d.gate = gate_end ? '0 : s_q.gate + GW'(1);
        if (perr_vld_i)
            s_d.upd = upd_boundary ? '0 : s_q.upd + UW'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    for (genvar g = 0; g < NUM_REF; g++) begin : g_ref
        logic is_sel;
        assign is_sel = (sel_i == 1'(g));

        refq_sync_edge u_sync (
            .clk    (clk),
            .rst_n  (rst_n),
            .ref_i  (ref_clk_i[g]),
            .rise_o (rise[g])
        );

        refq_freq_chk #(
            .GATE_CYC  (GATE_CYC),
            .NOM_EDGES (NOM_EDGES),
            .QUAL_PM   (QUAL_PM),
            .DISQ_PM   (DISQ_PM)
        ) u_freq (
            .clk        (clk),
            .rst_n      (rst_n),
            .gate_end_i (gate_end),
            .rise_i     (rise[g]),
            .freq_ok_o  (freq_ok[g])
        );

        refq_phase_chk #(
            .PERR_W (PERR_W),
            .WIN_PS (WIN_PS)
        ) u_phase (
            .clk        (clk),
            .rst_n      (rst_n),
            .strobe_i   (perr_vld_i & is_sel),
            .perr_i     (perr_i),
            .phase_ok_o (phase_ok[g])
        );

        assign fail_now[g] = amp_fault_i[g] | ~freq_ok[g] | (is_sel & ~phase_ok[g]);

        refq_flag_latch u_flag (
            .clk        (clk),
            .rst_n      (rst_n),
            .boundary_i (upd_boundary),
            .fail_now_i (fail_now[g]),
            .fail_n_o   (fail_n_o[g])
        );
    end
endmodule

// File: rtl/refq_monitor_chk.sv
module refq_monitor_chk #(
    parameter int PERR_W = 12,
    parameter int WIN_PS = 750
) (
    input logic              clk,
    input logic              rst_n,
    input logic              sel_i,
    input logic [1:0]        amp_fault_i,
    input logic [PERR_W-1:0] perr_i,
    input logic              perr_vld_i,
    input logic [1:0]        fail_n_o,
    input logic              upd_boundary,
    input logic              gate_end,
    input logic [1:0]        freq_ok,
    input logic [1:0]        phase_ok
);
    localparam logic [PERR_W-1:0] WIN_V = PERR_W'(WIN_PS);

    p_reset_high_r1: assert property (@(posedge clk)
        !rst_n |-> fail_n_o == 2'b11);

    p_hold_off_boundary_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !upd_boundary |=> $stable(fail_n_o));

    p_amp0_latched_r3: assert property (@(posedge clk) disable iff (!rst_n)
        upd_boundary && amp_fault_i[0] |=> !fail_n_o[0]);

    p_amp1_latched_r3: assert property (@(posedge clk) disable iff (!rst_n)
        upd_boundary && amp_fault_i[1] |=> !fail_n_o[1]);

    p_freq_only_at_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !gate_end |=> $stable(freq_ok));

    p_fall_on_violation0_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(phase_ok[0]) |-> $past(perr_vld_i && !sel_i && (perr_i > WIN_V)));

    p_fall_on_violation1_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(phase_ok[1]) |-> $past(perr_vld_i && sel_i && (perr_i > WIN_V)));

    p_regain_clean0_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(phase_ok[0]) |-> $past(perr_vld_i && !sel_i && (perr_i <= WIN_V)));

    p_regain_clean1_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(phase_ok[1]) |-> $past(perr_vld_i && sel_i && (perr_i <= WIN_V)));

    p_unselected_frozen0_r10: assert property (@(posedge clk) disable iff (!rst_n)
        sel_i |=> $stable(phase_ok[0]));

    p_unselected_frozen1_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !sel_i |=> $stable(phase_ok[1]));
endmodule

bind refq_monitor refq_monitor_chk #(
    .PERR_W (PERR_W),
    .WIN_PS (WIN_PS)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .sel_i        (sel_i),
    .amp_fault_i  (amp_fault_i),
    .perr_i       (perr_i),
    .perr_vld_i   (perr_vld_i),
    .fail_n_o     (fail_n_o),
    .upd_boundary (upd_boundary),
    .gate_end     (gate_end),
    .freq_ok      (freq_ok),
    .phase_ok     (phase_ok)
);

// File: tb/refq_monitor_test.sv
`timescale 1ns/1ps
module refq_monitor_test;
    localparam int GATE = 1024;
    localparam int NOM  = 256;
    localparam int QPM  = 24;
    localparam int DPM  = 80;
    localparam int WIN  = 750;
    localparam int UPD  = 128;
    localparam int QTOL = NOM * QPM / 1000;
    localparam int DTOL = NOM * DPM / 1000;
    localparam int INC_NOM = 32768;
    localparam int INC_P1  = 33096;
    localparam int INC_P5  = 34406;
    localparam int INC_P12 = 36700;

    logic        clk = 1'b0;
    logic        rst_n = 1'b1;
    logic [1:0]  ref_clk = 2'b00;
    logic        sel = 1'b0;
    logic [1:0]  amp = 2'b00;
    logic [11:0] perr = '0;
    logic        vld = 1'b0;
    logic [1:0]  fail_n;

    int compared = 0;
    int mismatched = 0;
    int n_strobe = 0;
    bit done = 0;
    string tag = "R1";
    int inc [2] = '{INC_NOM, INC_NOM};
    int acc [2] = '{0, 0};

    always #2 clk = ~clk;

    refq_monitor #(
        .GATE_CYC(GATE), .NOM_EDGES(NOM), .QUAL_PM(QPM), .DISQ_PM(DPM),
        .WIN_PS(WIN), .UPD_LEN(UPD), .PERR_W(12)
    ) uut (
        .clk(clk), .rst_n(rst_n), .ref_clk_i(ref_clk), .sel_i(sel),
        .amp_fault_i(amp), .perr_i(perr), .perr_vld_i(vld), .fail_n_o(fail_n)
    );

    // reference clock generators: fractional accumulators stepped mid-cycle
    initial begin
        forever begin
            @(negedge clk);
            for (int c = 0; c < 2; c++) begin
                acc[c] = acc[c] + inc[c];
                if (acc[c] >= 65536) begin
                    acc[c] = acc[c] - 65536;
                    ref_clk[c] = ~ref_clk[c];
                end
            end
        end
    end

    // behavioural reference model
    int m_samp [2][3];
    int m_cnt [2];
    bit m_fok [2];
    int m_hist [2];
    int m_run [2];
    bit m_pok [2];
    bit m_sticky [2];
    bit m_flag [2] = '{1'b1, 1'b1};
    int m_gate = 0;
    int m_upd = 0;

    always @(posedge clk or negedge rst_n) begin : model
        bit fnow [2];
        bit bnd;
        int rise, meas, dev, ones, ch, v;
        if (!rst_n) begin
            for (int c = 0; c < 2; c++) begin
                for (int k = 0; k < 3; k++) m_samp[c][k] = 0;
                m_cnt[c] = 0; m_fok[c] = 0; m_hist[c] = 0; m_run[c] = 0;
                m_pok[c] = 0; m_sticky[c] = 0; m_flag[c] = 1;
            end
            m_gate = 0;
            m_upd = 0;
        end else begin
            for (int c = 0; c < 2; c++)
                fnow[c] = amp[c] || !m_fok[c] || ((sel == c[0]) && !m_pok[c]);
            bnd = vld && (m_upd == UPD - 1);
            for (int c = 0; c < 2; c++) begin
                if (bnd) begin
                    m_flag[c] = !(m_sticky[c] || fnow[c]);
                    m_sticky[c] = 0;
                end else begin
                    m_sticky[c] = m_sticky[c] || fnow[c];
                end
            end
            if (vld) m_upd = bnd ? 0 : m_upd + 1;
            for (int c = 0; c < 2; c++) begin
                rise = (m_samp[c][1] == 1 && m_samp[c][2] == 0) ? 1 : 0;
                m_samp[c][2] = m_samp[c][1];
                m_samp[c][1] = m_samp[c][0];
                m_samp[c][0] = ref_clk[c] ? 1 : 0;
                if (m_gate == GATE - 1) begin
                    meas = m_cnt[c] + rise;
                    dev = (meas >= NOM) ? meas - NOM : NOM - meas;
                    if (m_fok[c]) m_fok[c] = (dev <= DTOL);
                    else          m_fok[c] = (dev <= QTOL);
                    m_cnt[c] = 0;
                end else begin
                    m_cnt[c] = m_cnt[c] + rise;
                end
            end
            m_gate = (m_gate == GATE - 1) ? 0 : m_gate + 1;
            if (vld) begin
                ch = sel ? 1 : 0;
                v = (perr > WIN) ? 1 : 0;
                m_hist[ch] = ((m_hist[ch] << 1) | v) & 255;
                m_run[ch] = v ? 0 : ((m_run[ch] >= 8) ? 8 : m_run[ch] + 1);
                ones = 0;
                for (int b = 0; b < 8; b++) ones = ones + ((m_hist[ch] >> b) & 1);
                if (m_pok[ch] && ones > 5) m_pok[ch] = 0;
                else if (!m_pok[ch] && m_run[ch] == 8) m_pok[ch] = 1;
            end
        end
    end

    // compare every clock, shortly after the edge
    always @(posedge clk) begin
        #1;
        for (int c = 0; c < 2; c++) begin
            compared++;
            if (fail_n[c] !== m_flag[c]) begin
                mismatched++;
                $display("FAIL %s ref%0d fail_n actual %0b expected %0b at %0t",
                         tag, c, fail_n[c], m_flag[c], $time);
            end
        end
    end

    task automatic check_pt(input logic [1:0] exp, input string rq);
        @(posedge clk);
        #1;
        compared++;
        if (fail_n !== exp) begin
            mismatched++;
            $display("FAIL %s flags actual %b expected %b", rq, fail_n, exp);
        end
    endtask

    task automatic strobe(input int val, input logic [1:0] amask);
        @(negedge clk);
        perr = 12'(val);
        vld = 1'b1;
        amp = amask;
        n_strobe++;
        @(negedge clk);
        vld = 1'b0;
        amp = 2'b00;
        @(negedge clk);
        @(negedge clk);
    endtask

    // pattern bit 7 first: 1 means violation
    task automatic run_pattern(input int n, input logic [7:0] pat);
        for (int i = 0; i < n; i++) begin
            if (pat[7 - (i % 8)]) strobe((i % 2) ? 751 : 4095, 2'b00);
            else                  strobe((i % 2) ? 750 : 100, 2'b00);
        end
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            mismatched++;
            $display("FAIL watchdog expired, tag %s", tag);
            finish_run();
        end
    end

    initial begin
        #1 rst_n = 1'b0;
        tag = "R1";
        check_pt(2'b11, "R1");
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        check_pt(2'b11, "R1");

        tag = "R4 R5 R9 R11";
        run_pattern(800, 8'h00);
        check_pt(2'b11, "R5");

        tag = "R6";
        inc[1] = INC_P5;
        run_pattern(800, 8'h00);
        check_pt(2'b11, "R6");

        tag = "R6 R11";
        inc[1] = INC_P12;
        run_pattern(800, 8'h00);
        check_pt(2'b01, "R6");

        tag = "R5 R6";
        inc[1] = INC_P5;
        run_pattern(800, 8'h00);
        check_pt(2'b01, "R6");

        tag = "R5";
        inc[1] = INC_P1;
        run_pattern(900, 8'h00);
        check_pt(2'b11, "R5");

        tag = "R7 R8";
        run_pattern(300, 8'b11111000);
        check_pt(2'b11, "R8");

        tag = "R8";
        run_pattern(300, 8'b11111100);
        check_pt(2'b10, "R8");

        tag = "R9";
        run_pattern(200, 8'b00000001);
        check_pt(2'b10, "R9");

        run_pattern(400, 8'h00);
        check_pt(2'b11, "R9");

        tag = "R10";
        run_pattern(100, 8'b11111100);
        @(negedge clk) sel = 1'b1;
        run_pattern(400, 8'h00);
        check_pt(2'b11, "R10");

        run_pattern(300, 8'b11111100);
        check_pt(2'b01, "R10");
        run_pattern(400, 8'h00);
        check_pt(2'b11, "R10");

        tag = "R3 R2";
        run_pattern(40, 8'h00);
        @(negedge clk) amp = 2'b01;
        @(negedge clk) amp = 2'b00;
        run_pattern(300, 8'h00);

        tag = "R3";
        while ((n_strobe % UPD) != UPD - 1) strobe(100, 2'b00);
        strobe(100, 2'b10);
        check_pt(2'b01, "R3");
        run_pattern(300, 8'h00);
        check_pt(2'b11, "R3");

        tag = "R1";
        @(negedge clk) rst_n = 1'b0;
        check_pt(2'b11, "R1");
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        n_strobe = 0;
        tag = "R1 R2 R5";
        run_pattern(800, 8'h00);
        check_pt(2'b11, "R5");

        done = 1;
        finish_run();
    end
endmodule